// File: doc/BRIEF.md
# Smooth Digital Clock Calibrator

This block trims the effective rate of a low-speed calendar clock. It runs on the reference clock itself and produces one weighted enable per reference cycle for the prescaler that follows. The weight is 1 in a normal cycle. It is 0 in a cycle that is removed ("masked"). It is 2 in a cycle that counts double, which stands in for one inserted pulse. Removals are spread evenly over a calibration window of 2^WIN_LOG2 reference cycles. They are picked by comparing the bit-reversed window counter with the programmed minus-count. The plus option marks one cycle in every 2^(WIN_LOG2-MINUS_W) as double weight. The net pulses gained per full window are therefore 512·plus − minus at the default widths.

Software loads a new setting with a one-cycle write strobe. The setting carries a minus-count, a plus bit, and two bits that select the half-length or quarter-length window. The accepted setting is staged and a pending flag rises. The staged setting replaces the active one at the first window boundary, and the flag drops at that moment. Writes made while the flag is high are discarded. A shorter window forces the low minus-count bits to zero so that the removals still divide evenly.

Top module: `smooth_calibrator`

## Requirements
- R1: After reset the pending flag is 0 and the active setting is zero, so `tickInc` is 1 and `tickEn` is 1 in every cycle.
- R2: When the active minus-count is 0 and plus is 0, every reference cycle gives `tickInc` = 1.
- R3: A reference cycle is masked (`tickInc` = 0) when the bit-reversed free-running window counter is below the active minus-count. With the full window and plus 0, exactly minus cycles per window are masked. For example, minus = 2 masks window offsets 0 and 2^(WIN_LOG2-1).
- R4: With plus = 1, each cycle whose counter's low WIN_LOG2−MINUS_W bits are all ones has `tickInc` = 2. Over a full window the sum of `tickInc` is 2^WIN_LOG2 + 512·plus − minus.
- R5: Window code {win8,win16} = 01 selects a window of 2^(WIN_LOG2−1) cycles and forces minus bit 0 to 0. Each window then sums to L − minus/2 + 256·plus.
- R6: Window code 10 selects a window of 2^(WIN_LOG2−2) cycles and forces minus bits 1:0 to 0. Each window then sums to L − minus/4 + 128·plus.
- R7: A write with both window bits set (code 11) is ignored: the pending flag stays 0 and the active behaviour does not change.
- R8: An accepted write raises `calPending` in the cycle after the write strobe.
- R9: Writes made while `calPending` is 1 are discarded. The setting staged first is the one that takes effect.
- R10: `calPending` falls exactly when a new window of the currently active length begins. The new setting governs every cycle from that point on.
- R11: `tickInc` is never 3. `tickEn` is 1 exactly when `tickInc` is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgWr | input | 1 | One-cycle strobe that offers a new setting |
| cfgMinus | input | MINUS_W | Number of cycles to remove per full window |
| cfgPlus | input | 1 | Enables one double-weight cycle per 2^(WIN_LOG2−MINUS_W) cycles |
| cfgWin16 | input | 1 | Selects the half-length window |
| cfgWin8 | input | 1 | Selects the quarter-length window |
| tickEn | output | 1 | Prescaler enable for this cycle |
| tickInc | output | 2 | Prescaler increment for this cycle: 0, 1 or 2 |
| calPending | output | 1 | A staged setting is waiting for the next window boundary |

## Verification
The bench builds the block with WIN_LOG2 = 12 and the default MINUS_W = 9. A full window is then 4096 cycles and a double-weight cycle falls every 8 cycles. This keeps the same 512-insert-per-window ratio as the default build, so the extremes of the minus-count (0, 1, 511) and every window size can be summed over whole windows in a short run. The reduced window also lets the bench land on the exact masked offsets, see handovers between windows of different lengths, and check that the low minus-count bits are forced at the short windows.

// File: rtl/calib_pkg.sv
package calib_pkg;

  // Window selection code, written as {win8, win16}
  typedef enum logic [1:0] {
    WIN_FULL    = 2'b00,
    WIN_HALF    = 2'b01,
    WIN_QUARTER = 2'b10,
    WIN_BAD     = 2'b11
  } winSel_t;

  // Strobes sent from the control to the datapath
  typedef struct packed {
    logic stage;   // capture the offered setting into the staging registers
    logic commit;  // move the staged setting into the active registers
  } calStrobe_t;

endpackage

// File: rtl/calib_ctrl.sv
module calib_ctrl
  import calib_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgWr,
  input  winSel_t    winReq,
  input  logic       winEnd,
  output calStrobe_t strobe,
  output logic       pending
);

  logic pendQ;
  logic legal;
  logic accept;
  logic commit;

  assign legal  = (winReq != WIN_BAD);
  assign accept = cfgWr && !pendQ && legal;
  assign commit = pendQ && winEnd;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       pendQ <= 1'b0;
    else if (accept) pendQ <= 1'b1;
    else if (commit) pendQ <= 1'b0;
  end

  assign strobe.stage  = accept;
  assign strobe.commit = commit;
  assign pending       = pendQ;

  // R8: an accepted write raises the pending flag one cycle later
  p_pend_rise_r8: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWr && !pendQ && winReq != WIN_BAD) |=> pendQ);

  // R9: the flag holds until a window boundary arrives
  p_pend_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (pendQ && !winEnd) |=> pendQ);

  // R7: an illegal window code never starts a pending update
  p_illegal_r7: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWr && winReq == WIN_BAD && !pendQ) |=> !pendQ);

  // R10: the flag only drops on a window boundary
  p_fall_r10: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pendQ) |-> $past(winEnd));

endmodule

// File: rtl/calib_shaper.sv
module calib_shaper
  import calib_pkg::*;
#(
  parameter int WIN_LOG2 = 20,
  parameter int MINUS_W  = 9
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [WIN_LOG2-1:0] winCnt,
  input  logic [MINUS_W-1:0]  minus,
  input  logic                plus,
  input  winSel_t             winSel,
  output logic [1:0]          incr
);

  localparam int PLUS_LOG2 = WIN_LOG2 - MINUS_W;

  logic [WIN_LOG2-1:0] revCnt;
  logic                maskCyc;
  logic                insCyc;

  // Bit reversal spreads the removed cycles evenly over the window
  for (genvar i = 0; i < WIN_LOG2; i++) begin : g_rev
    assign revCnt[i] = winCnt[WIN_LOG2-1-i];
  end

  assign maskCyc = revCnt < {{PLUS_LOG2{1'b0}}, minus};
  assign insCyc  = plus && (&winCnt[PLUS_LOG2-1:0]);

  always_comb begin
    if (maskCyc && insCyc) incr = 2'd1;
    else if (maskCyc)      incr = 2'd0;
    else if (insCyc)       incr = 2'd2;
    else                   incr = 2'd1;
  end

  // R2: a zero setting passes every cycle at unit weight
  p_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    (minus == '0 && !plus) |-> (incr == 2'd1));

  // R11: the increment stays within 0..2
  p_range_r11: assert property (@(posedge clk) disable iff (!rstN)
    incr != 2'd3);

  // R5: the half window never sees an odd minus-count
  p_half_r5: assert property (@(posedge clk) disable iff (!rstN)
    (winSel == WIN_HALF) |-> (minus[0] == 1'b0));

  // R6: the quarter window never sees minus bits 1:0 set
  p_quarter_r6: assert property (@(posedge clk) disable iff (!rstN)
    (winSel == WIN_QUARTER) |-> (minus[1:0] == 2'b00));

endmodule

// File: rtl/calib_datapath.sv
module calib_datapath
  import calib_pkg::*;
#(
  parameter int WIN_LOG2 = 20,
  parameter int MINUS_W  = 9
) (
  input  logic               clk,
  input  logic               rstN,
  input  calStrobe_t         strobe,
  input  logic [MINUS_W-1:0] cfgMinus,
  input  logic               cfgPlus,
  input  winSel_t            winReq,
  output logic               winEnd,
  output logic [1:0]         incr
);

  logic [WIN_LOG2-1:0] winCnt;
  logic [MINUS_W-1:0]  minusForced;
  logic [MINUS_W-1:0]  stMinus, actMinus;
  logic                stPlus, actPlus;
  winSel_t             stWin, actWin;

  // Short windows clear the minus-count bits they cannot divide evenly
  always_comb begin
    minusForced = cfgMinus;
    if (winReq == WIN_HALF)    minusForced[0]   = 1'b0;
    if (winReq == WIN_QUARTER) minusForced[1:0] = 2'b00;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) winCnt <= '0;
    else       winCnt <= winCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stMinus <= '0;
      stPlus  <= 1'b0;
      stWin   <= WIN_FULL;
    end else if (strobe.stage) begin
      stMinus <= minusForced;
      stPlus  <= cfgPlus;
      stWin   <= winReq;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      actMinus <= '0;
      actPlus  <= 1'b0;
      actWin   <= WIN_FULL;
    end else if (strobe.commit) begin
      actMinus <= stMinus;
      actPlus  <= stPlus;
      actWin   <= stWin;
    end
  end

  // Last cycle of the active window
  always_comb begin
    unique case (actWin)
      WIN_HALF:    winEnd = &winCnt[WIN_LOG2-2:0];
      WIN_QUARTER: winEnd = &winCnt[WIN_LOG2-3:0];
      default:     winEnd = &winCnt;
    endcase
  end

  calib_shaper #(
    .WIN_LOG2 (WIN_LOG2),
    .MINUS_W  (MINUS_W)
  ) u_shaper (
    .clk    (clk),
    .rstN   (rstN),
    .winCnt (winCnt),
    .minus  (actMinus),
    .plus   (actPlus),
    .winSel (actWin),
    .incr   (incr)
  );

  // R10: a commit only arrives on the last cycle of a window
  p_commit_aligned_r10: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commit |-> winEnd);

  // R7: the illegal code never reaches the active registers
  p_no_bad_win_r7: assert property (@(posedge clk) disable iff (!rstN)
    actWin != WIN_BAD);

endmodule

// File: rtl/smooth_calibrator.sv
module smooth_calibrator
  import calib_pkg::*;
#(
  parameter int WIN_LOG2 = 20,
  parameter int MINUS_W  = 9
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWr,
  input  logic [MINUS_W-1:0] cfgMinus,
  input  logic               cfgPlus,
  input  logic               cfgWin16,
  input  logic               cfgWin8,
  output logic               tickEn,
  output logic [1:0]         tickInc,
  output logic               calPending
);

  calStrobe_t strobe;
  winSel_t    winReq;
  logic       winEnd;

  assign winReq = winSel_t'({cfgWin8, cfgWin16});

  calib_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .cfgWr   (cfgWr),
    .winReq  (winReq),
    .winEnd  (winEnd),
    .strobe  (strobe),
    .pending (calPending)
  );

  calib_datapath #(
    .WIN_LOG2 (WIN_LOG2),
    .MINUS_W  (MINUS_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .cfgMinus (cfgMinus),
    .cfgPlus  (cfgPlus),
    .winReq   (winReq),
    .winEnd   (winEnd),
    .incr     (tickInc)
  );

  assign tickEn = (tickInc != 2'd0);

  // R11: the enable agrees with the increment
  p_en_match_r11: assert property (@(posedge clk) disable iff (!rstN)
    tickEn == (tickInc != 2'd0));

endmodule

// File: tb/sim_smooth_calibrator.sv
`timescale 1ns/1ps
module sim_smooth_calibrator;

  localparam int WL    = 12;
  localparam int MW    = 9;
  localparam int FULLN = 1 << WL;
  localparam int NV    = 9;

  // minus, plus, win16, win8, expected sum over one active window
  localparam int VM[NV]   = '{0, 1, 511, 0, 511, 100, 101, 7, 255};
  localparam int VP[NV]   = '{0, 0, 0,   1, 1,   1,   0,   0, 1};
  localparam int V16[NV]  = '{0, 0, 0,   0, 0,   1,   1,   0, 0};
  localparam int V8[NV]   = '{0, 0, 0,   0, 0,   0,   0,   1, 1};
  localparam int VSUM[NV] = '{4096, 4095, 3585, 4608, 4097, 2254, 1998, 1023, 1089};

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cfgWr = 1'b0;
  logic [MW-1:0] cfgMinus = '0;
  logic          cfgPlus = 1'b0;
  logic          cfgWin16 = 1'b0;
  logic          cfgWin8 = 1'b0;
  logic          tickEn;
  logic [1:0]    tickInc;
  logic          calPending;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int actL   = FULLN;

  always #10 clk = ~clk;

  always @(posedge clk) if (rstN) cyc <= cyc + 1;

  smooth_calibrator #(.WIN_LOG2(WL), .MINUS_W(MW)) u0 (
    .clk(clk), .rstN(rstN), .cfgWr(cfgWr), .cfgMinus(cfgMinus),
    .cfgPlus(cfgPlus), .cfgWin16(cfgWin16), .cfgWin8(cfgWin8),
    .tickEn(tickEn), .tickInc(tickInc), .calPending(calPending)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int winLen(input int w16, input int w8);
    if (w8 != 0)  return FULLN / 4;
    if (w16 != 0) return FULLN / 2;
    return FULLN;
  endfunction

  task automatic writeCfg(input int m, input int p, input int w16, input int w8);
    @(negedge clk);
    cfgWr    = 1'b1;
    cfgMinus = MW'(m);
    cfgPlus  = p[0];
    cfgWin16 = w16[0];
    cfgWin8  = w8[0];
    @(negedge clk);
    cfgWr = 1'b0;
  endtask

  // Wait for the staged setting to take over; check alignment (R10)
  task automatic waitCommit(input int newL);
    while (calPending) @(negedge clk);
    check((cyc % actL) == 0, "R10 boundary", cyc % actL, 0);
    actL = newL;
  endtask

  task automatic sumWindow(input int len, output int s);
    s = 0;
    for (int i = 0; i < len; i++) begin
      s += int'(tickInc);
      check(tickInc != 2'd3 && tickEn == (tickInc != 0), "R11 encoding", int'(tickInc), 1);
      @(negedge clk);
    end
  endtask

  task automatic waitOff(input int off);
    while ((cyc % FULLN) != off) @(negedge clk);
  endtask

  initial begin
    int s;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1: reset state
    check(calPending == 1'b0, "R1 pending", int'(calPending), 0);
    check(tickInc == 2'd1, "R1 inc", int'(tickInc), 1);
    @(negedge clk);
    // R2: zero setting passes everything
    sumWindow(64, s);
    check(s == 64, "R2 passthrough", s, 64);

    // Table of settings (R3, R4, R5, R6, R8, R10)
    for (int v = 0; v < NV; v++) begin
      writeCfg(VM[v], VP[v], V16[v], V8[v]);
      check(calPending == 1'b1, "R8 pending rise", int'(calPending), 1);
      waitCommit(winLen(V16[v], V8[v]));
      sumWindow(actL, s);
      check(s == VSUM[v], (V8[v] != 0) ? "R6 sum" : (V16[v] != 0) ? "R5 sum" :
            (VP[v] != 0) ? "R4 sum" : "R3 sum", s, VSUM[v]);
    end

    // R7: both window bits set is ignored
    writeCfg(0, 0, 1, 1);
    check(calPending == 1'b0, "R7 no pending", int'(calPending), 0);
    sumWindow(actL, s);
    check(s == 1089, "R7 unchanged", s, 1089);

    // R9: second write while pending is dropped
    writeCfg(0, 0, 0, 0);
    writeCfg(511, 1, 0, 0);
    check(calPending == 1'b1, "R9 still pending", int'(calPending), 1);
    waitCommit(FULLN);
    sumWindow(actL, s);
    check(s == FULLN, "R9 first write kept", s, FULLN);

    // R3: exact masked offsets with minus = 2
    writeCfg(2, 0, 0, 0);
    waitCommit(FULLN);
    waitOff(0);
    check(tickInc == 2'd0, "R3 offset 0", int'(tickInc), 0);
    @(negedge clk);
    check(tickInc == 2'd1, "R3 offset 1", int'(tickInc), 1);
    waitOff(FULLN / 2);
    check(tickInc == 2'd0, "R3 offset half", int'(tickInc), 0);
    @(negedge clk);
    check(tickInc == 2'd1, "R3 offset half+1", int'(tickInc), 1);

    // R4: double-weight cycle position with plus only
    writeCfg(0, 1, 0, 0);
    waitCommit(FULLN);
    waitOff(7);
    check(tickInc == 2'd2, "R4 offset 7", int'(tickInc), 2);
    @(negedge clk);
    check(tickInc == 2'd1, "R4 offset 8", int'(tickInc), 1);

    // R2: back to zero setting
    writeCfg(0, 0, 0, 0);
    waitCommit(FULLN);
    sumWindow(256, s);
    check(s == 256, "R2 zero again", s, 256);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(20.0 * 190000);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule